// File: doc/BRIEF.md
# Banked Pipelined Memory Cluster

This block is a word memory split into many independent banks that sit behind one request port and one response port. A request packet names a bank, a row and an operation, and it carries a tag and a word of write data. The packet is captured once and then offered to every bank at the same time. Each bank has its own selector that compares the packet's bank field with the bank's fixed number. Only the bank whose number matches starts the access.

Inside a bank, the row address is resolved one bit per pipeline stage. Each stage refines a one-hot row select, so the select grows from two lines to the full row count. The write data, the operation and the tag travel through a delay line of the same length beside the row decode. At the end of that pipeline the bank reads or writes its row. It then hands a response packet to a shared merge stage, which registers the response onto the output port.

Accesses to different banks overlap freely, so one request per cycle can be accepted while the banks differ. A request to a bank whose pipeline is still occupied is held off through the ready signal until that bank is free. Every access takes the same number of cycles, so responses leave in the order they complete, at most one per cycle, and each response carries the requester's tag.

Top module: `bank_cluster`

## Requirements
- R1: The cluster holds 128 banks of 128 rows. Each row is one 64-bit word. A read returns the word most recently written to the same bank and row. A write changes no other row, and no other bank's row with the same row number.
- R2: In a request packet (85 bits), bits [84:78] are the bank, [77:71] the row, bit [70] the operation (1 = write, 0 = read), [69:64] the tag and [63:0] the write data.
- R3: In a response packet (85 bits), bits [84:78] are the bank, [77:71] the row and [69:64] the tag of the request. Bit [70] is 1 for a write acknowledge and 0 for read data. Bits [63:0] hold the read word for a read and all zeros for a write acknowledge.
- R4: Every accepted request produces exactly one response. rsp_valid rises 9 clock edges after the edge at which the request was accepted (req_valid and req_ready both high).
- R5: While every bank pipeline is idle, req_ready is high. Requests to distinct idle banks are accepted on consecutive cycles with no stall.
- R6: A request to a bank that has an access in flight sees req_ready low. When such a request is held, it is accepted exactly 9 edges after the earlier request to that bank, and never on the cycle right after it.
- R7: While rst is high and on the cycle after it falls, rsp_valid is low. With no bank busy, req_ready is high after reset.
- R8: Responses appear in the order the requests were accepted, one per cycle at most. No response appears without a matching request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request packet present |
| req_ready | output | 1 | Addressed bank can take the request this cycle |
| req_pkt | input | 85 | Request packet (bank, row, op, tag, data) |
| rsp_valid | output | 1 | Response packet present for one cycle |
| rsp_pkt | output | 85 | Response packet (bank, row, ack flag, tag, data) |

## Verification
The properties assume the following about the inputs:
- The bank field of every request names an existing bank.
- A requester keeps req_valid and req_pkt steady until the packet is accepted, so the acceptance edge is well defined.
- Read data is meaningful only for rows that have been written since power-up.

The stimulus holds each packet until ready is sampled high, uses only the default power-of-two bank count, and reads only locations it has written. It predicts each read word from its own copy of the array, which it updates in issue order. Issue order matches execution order because accesses to one bank are serialised.

// File: rtl/bc_pkg.sv
package bc_pkg;
  localparam int BC_BANKS_DEF    = 128;
  localparam int BC_ROW_BITS_DEF = 7;
  localparam int BC_WORD_W_DEF   = 64;
  localparam int BC_TAG_W_DEF    = 6;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } bc_op_e;
endpackage

// File: rtl/bc_row_decoder.sv
module bc_row_decoder #(
  parameter int ROW_BITS = 7,
  parameter int PAY_W    = 71
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_v,
  input  logic [ROW_BITS-1:0]       in_row,
  input  logic [PAY_W-1:0]          in_pay,
  output logic                      out_v,
  output logic [(1<<ROW_BITS)-1:0]  out_sel,
  output logic [PAY_W-1:0]          out_pay,
  output logic                      busy
);
  logic [ROW_BITS-1:0] v_pipe;
  logic [PAY_W-1:0]    pay_pipe [ROW_BITS];
  logic [ROW_BITS-1:0] rem_pipe [ROW_BITS-1];

  always_ff @(posedge clk) begin
    if (rst) v_pipe <= '0;
    else     v_pipe <= {v_pipe[ROW_BITS-2:0], in_v};
  end

  always_ff @(posedge clk) begin
    pay_pipe[0] <= in_pay;
    for (int k = 1; k < ROW_BITS; k++) pay_pipe[k] <= pay_pipe[k-1];
    rem_pipe[0] <= in_row >> 1;
    for (int k = 1; k < ROW_BITS - 1; k++) rem_pipe[k] <= rem_pipe[k-1] >> 1;
  end

  for (genvar k = 0; k < ROW_BITS; k++) begin : g_stg
    logic [(2<<k)-1:0] part;
    if (k == 0) begin : g_first
      always_ff @(posedge clk) part <= {in_row[0], ~in_row[0]};
    end else begin : g_next
      logic bitk;
      assign bitk = rem_pipe[k-1][0];
      always_ff @(posedge clk)
        part <= {g_stg[k-1].part & {(1<<k){bitk}},
                 g_stg[k-1].part & {(1<<k){~bitk}}};
    end
  end

  assign out_v   = v_pipe[ROW_BITS-1];
  assign out_sel = g_stg[ROW_BITS-1].part;
  assign out_pay = pay_pipe[ROW_BITS-1];
  assign busy    = |v_pipe;
endmodule

// File: rtl/bc_bank.sv
module bc_bank
  import bc_pkg::*;
#(
  parameter int BANK_ID   = 0,
  parameter int BANK_BITS = 7,
  parameter int ROW_BITS  = 7,
  parameter int TAG_W     = 6,
  parameter int WORD_W    = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 hdr_v,
  input  logic [BANK_BITS-1:0] hdr_bank,
  input  logic [ROW_BITS-1:0]  hdr_row,
  input  logic                 hdr_we,
  input  logic [TAG_W-1:0]     hdr_tag,
  input  logic [WORD_W-1:0]    hdr_data,
  output logic                 busy,
  output logic                 rsp_v,
  output logic [BANK_BITS+ROW_BITS+1+TAG_W+WORD_W-1:0] rsp_pkt
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int PAY_W = 1 + TAG_W + WORD_W;

  logic              sel;
  logic              dec_v;
  logic [ROWS-1:0]   dec_sel;
  logic [PAY_W-1:0]  dec_pay;
  logic [ROW_BITS-1:0] dec_addr;
  bc_op_e            dec_op;
  logic [TAG_W-1:0]  dec_tag;
  logic [WORD_W-1:0] dec_data;

  logic [WORD_W-1:0] mem [ROWS];
  logic [WORD_W-1:0] rd_q;
  logic [ROW_BITS-1:0] row_q;
  logic [TAG_W-1:0]  tag_q;
  logic              we_q;

  assign sel = hdr_v && (hdr_bank == BANK_BITS'(BANK_ID));

  bc_row_decoder #(.ROW_BITS(ROW_BITS), .PAY_W(PAY_W)) u_dec (
    .clk(clk), .rst(rst), .in_v(sel), .in_row(hdr_row),
    .in_pay({hdr_we, hdr_tag, hdr_data}),
    .out_v(dec_v), .out_sel(dec_sel), .out_pay(dec_pay), .busy(busy)
  );

  assign dec_op   = bc_op_e'(dec_pay[PAY_W-1]);
  assign dec_tag  = dec_pay[WORD_W +: TAG_W];
  assign dec_data = dec_pay[WORD_W-1:0];

  always_comb begin
    dec_addr = '0;
    for (int i = 0; i < ROWS; i++)
      if (dec_sel[i]) dec_addr = dec_addr | ROW_BITS'(i);
  end

  always_ff @(posedge clk) begin
    if (dec_v && dec_op == OP_WRITE) mem[dec_addr] <= dec_data;
    rd_q <= mem[dec_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) rsp_v <= 1'b0;
    else     rsp_v <= dec_v;
    row_q <= dec_addr;
    tag_q <= dec_tag;
    we_q  <= (dec_op == OP_WRITE);
  end

  assign rsp_pkt = {BANK_BITS'(BANK_ID), row_q, we_q, tag_q,
                    we_q ? {WORD_W{1'b0}} : rd_q};
endmodule

// File: rtl/bc_resp_merge.sv
module bc_resp_merge #(
  parameter int NUM_BANKS = 128,
  parameter int PKT_W     = 85
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_v   [NUM_BANKS],
  input  logic [PKT_W-1:0] in_pkt [NUM_BANKS],
  output logic             out_v,
  output logic [PKT_W-1:0] out_pkt
);
  logic             any_v;
  logic [PKT_W-1:0] any_pkt;

  always_comb begin
    any_v   = 1'b0;
    any_pkt = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      any_v   = any_v | in_v[i];
      any_pkt = any_pkt | (in_pkt[i] & {PKT_W{in_v[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v   <= 1'b0;
      out_pkt <= '0;
    end else begin
      out_v   <= any_v;
      out_pkt <= any_pkt;
    end
  end
endmodule

// File: rtl/bank_cluster.sv
module bank_cluster
  import bc_pkg::*;
#(
  parameter int NUM_BANKS = BC_BANKS_DEF,
  parameter int ROW_BITS  = BC_ROW_BITS_DEF,
  parameter int WORD_W    = BC_WORD_W_DEF,
  parameter int TAG_W     = BC_TAG_W_DEF,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int PKT_W     = BANK_BITS + ROW_BITS + 1 + TAG_W + WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [PKT_W-1:0] req_pkt,
  output logic             rsp_valid,
  output logic [PKT_W-1:0] rsp_pkt
);
  localparam int TAG_LO  = WORD_W;
  localparam int OP_BIT  = WORD_W + TAG_W;
  localparam int ROW_LO  = OP_BIT + 1;
  localparam int BANK_LO = ROW_LO + ROW_BITS;

  logic                 hdr_v;
  logic [PKT_W-1:0]     hdr_pkt;
  logic [BANK_BITS-1:0] in_bank;
  logic [BANK_BITS-1:0] hdr_bank;
  logic [NUM_BANKS-1:0] bank_busy;
  logic                 bank_v   [NUM_BANKS];
  logic [PKT_W-1:0]     bank_pkt [NUM_BANKS];

  assign in_bank  = req_pkt[BANK_LO +: BANK_BITS];
  assign hdr_bank = hdr_pkt[BANK_LO +: BANK_BITS];
  assign req_ready = !bank_busy[in_bank] && !(hdr_v && hdr_bank == in_bank);

  always_ff @(posedge clk) begin
    if (rst) hdr_v <= 1'b0;
    else     hdr_v <= req_valid && req_ready;
    if (req_valid && req_ready) hdr_pkt <= req_pkt;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bc_bank #(
      .BANK_ID(b), .BANK_BITS(BANK_BITS), .ROW_BITS(ROW_BITS),
      .TAG_W(TAG_W), .WORD_W(WORD_W)
    ) u_bank (
      .clk(clk), .rst(rst), .hdr_v(hdr_v), .hdr_bank(hdr_bank),
      .hdr_row(hdr_pkt[ROW_LO +: ROW_BITS]), .hdr_we(hdr_pkt[OP_BIT]),
      .hdr_tag(hdr_pkt[TAG_LO +: TAG_W]), .hdr_data(hdr_pkt[WORD_W-1:0]),
      .busy(bank_busy[b]), .rsp_v(bank_v[b]), .rsp_pkt(bank_pkt[b])
    );
  end

  bc_resp_merge #(.NUM_BANKS(NUM_BANKS), .PKT_W(PKT_W)) u_merge (
    .clk(clk), .rst(rst), .in_v(bank_v), .in_pkt(bank_pkt),
    .out_v(rsp_valid), .out_pkt(rsp_pkt)
  );
endmodule

// File: rtl/bank_cluster_chk.sv
module bank_cluster_chk #(
  parameter int NUM_BANKS = 128,
  parameter int ROW_BITS  = 7,
  parameter int WORD_W    = 64,
  parameter int TAG_W     = 6,
  localparam int BANK_BITS = $clog2(NUM_BANKS),
  localparam int PKT_W     = BANK_BITS + ROW_BITS + 1 + TAG_W + WORD_W
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic [PKT_W-1:0] req_pkt,
  input logic             rsp_valid,
  input logic [PKT_W-1:0] rsp_pkt
);
  localparam int LAT    = ROW_BITS + 2;
  localparam int META_W = PKT_W - WORD_W;
  localparam int OP_BIT = WORD_W + TAG_W;
  localparam int BANK_LO = OP_BIT + 1 + ROW_BITS;

  logic              fire;
  logic [LAT:0]      fire_sr;
  logic [META_W-1:0] meta_sr [LAT+1];

  assign fire = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) fire_sr <= '0;
    else     fire_sr <= {fire_sr[LAT-1:0], fire};
    meta_sr[0] <= req_pkt[PKT_W-1:WORD_W];
    for (int k = 1; k <= LAT; k++) meta_sr[k] <= meta_sr[k-1];
  end

  // R7: response output quiet during and right after reset
  p_reset_quiet_r7: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R4 and R8: one response per accepted request, fixed distance
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == fire_sr[LAT]);

  // R3: response echoes bank, row, operation and tag of its request
  p_echo_r3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_pkt[PKT_W-1:WORD_W] == meta_sr[LAT]);

  // R3: write acknowledge carries zero data
  p_wack_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_pkt[OP_BIT]) |-> rsp_pkt[WORD_W-1:0] == '0);

  // R5: idle cluster is always ready
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (fire_sr[LAT-2:0] == '0) |-> req_ready);

  // R6: same bank cannot be taken on the very next cycle
  p_stall_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !(fire && req_pkt[BANK_LO +: BANK_BITS] == $past(req_pkt[BANK_LO +: BANK_BITS])));
endmodule

bind bank_cluster bank_cluster_chk #(
  .NUM_BANKS(NUM_BANKS), .ROW_BITS(ROW_BITS), .WORD_W(WORD_W), .TAG_W(TAG_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_pkt(req_pkt), .rsp_valid(rsp_valid), .rsp_pkt(rsp_pkt)
);

// File: tb/bank_cluster_bench.sv
module bank_cluster_bench;
  localparam int PKT_W = 85;

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic req_ready;
  logic [PKT_W-1:0] req_pkt;
  logic rsp_valid;
  logic [PKT_W-1:0] rsp_pkt;

  always #10 clk = ~clk;

  bank_cluster u_bank_cluster (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_pkt(req_pkt), .rsp_valid(rsp_valid), .rsp_pkt(rsp_pkt)
  );

  typedef struct {
    logic [PKT_W-1:0] pkt;
    int               due;
  } exp_t;

  exp_t        sb_q [$];
  logic [63:0] ref_mem [int];
  int cyc = 0;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [PKT_W-1:0] mk(input int b, input int r, input bit we,
                                           input int tag, input logic [63:0] d);
    return {b[6:0], r[6:0], we, tag[5:0], d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [PKT_W-1:0] act,
                       input logic [PKT_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: called at a falling edge; returns accept edge and stall count.
  task automatic send(input int b, input int r, input bit we, input int tag,
                      input logic [63:0] d, output int acc, output int stalls);
    exp_t e;
    logic [63:0] rd;
    int key;
    key = b * 128 + r;
    stalls = 0;
    req_pkt = mk(b, r, we, tag, d);
    req_valid = 1'b1;
    #1;
    while (!req_ready) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    if (we) begin
      ref_mem[key] = d;
      rd = '0;
    end else begin
      rd = ref_mem.exists(key) ? ref_mem[key] : 64'h0;
    end
    e.pkt = mk(b, r, we, tag, rd);
    e.due = cyc + 10;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor: compares each response with the head of the queue.
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rsp_valid) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R8 unexpected response", rsp_pkt, '0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check(cyc == e.due, "R4 response cycle", PKT_W'(cyc), PKT_W'(e.due));
          check(rsp_pkt == e.pkt, e.pkt[70] ? "R3 write ack" : "R1 read data",
                rsp_pkt, e.pkt);
        end
      end else if (sb_q.size() > 0 && sb_q[0].due < cyc) begin
        exp_t e;
        e = sb_q.pop_front();
        check(1'b0, "R4 missing response", '0, e.pkt);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R4 watchdog expired actual=%0d expected=done", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    int a0, a1, st, st_sum;
    rst = 1'b1;
    req_valid = 1'b0;
    req_pkt = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R7 valid in reset", PKT_W'(rsp_valid), '0);
    rst = 1'b0;
    @(negedge clk);
    #1;
    check(rsp_valid == 1'b0, "R7 valid after reset", PKT_W'(rsp_valid), '0);
    check(req_ready == 1'b1, "R7 ready after reset", PKT_W'(req_ready), 1);

    // R5 and R2: writes to sixteen distinct banks, back to back
    st_sum = 0;
    for (int i = 0; i < 16; i++) begin
      send(i, 5, 1'b1, i, 64'hA5A5_0000_0000_0000 | 64'(i * 4099), a1, st);
      if (i == 0) a0 = a1;
      st_sum += st;
    end
    check(st_sum == 0, "R5 stalls across banks", PKT_W'(st_sum), 0);
    check(a1 - a0 == 15, "R5 accept spacing", PKT_W'(a1 - a0), 15);

    // R1: read them back, distinct tags
    for (int i = 0; i < 16; i++) send(i, 5, 1'b0, 63 - i, 64'h0, a1, st);

    // R6: write then read the same bank immediately
    send(9, 3, 1'b1, 1, 64'hDEAD_BEEF_0123_4567, a0, st);
    send(9, 3, 1'b0, 2, 64'h0, a1, st);
    check(st == 8, "R6 stall cycles", PKT_W'(st), 8);
    check(a1 - a0 == 9, "R6 same-bank spacing", PKT_W'(a1 - a0), 9);

    // R1: same row number in neighbouring banks kept apart
    send(20, 7, 1'b1, 3, 64'h1111_2222_3333_4444, a1, st);
    send(21, 7, 1'b1, 4, 64'h5555_6666_7777_8888, a1, st);
    send(20, 7, 1'b0, 5, 64'h0, a1, st);
    send(21, 7, 1'b0, 6, 64'h0, a1, st);

    // R1 and R2: extreme bank and row numbers
    send(127, 127, 1'b1, 63, 64'hFFFF_FFFF_FFFF_FFFF, a1, st);
    send(0, 0, 1'b1, 0, 64'h0000_0000_0000_0001, a1, st);
    send(0, 127, 1'b1, 7, 64'h8000_0000_0000_0000, a1, st);
    send(127, 127, 1'b0, 8, 64'h0, a1, st);
    send(0, 0, 1'b0, 9, 64'h0, a1, st);
    send(0, 127, 1'b0, 10, 64'h0, a1, st);

    // R1: overwrite a row, then read the last value
    send(40, 9, 1'b1, 11, 64'h0BAD_0BAD_0BAD_0BAD, a1, st);
    send(40, 9, 1'b1, 12, 64'h600D_600D_600D_600D, a1, st);
    send(40, 9, 1'b0, 13, 64'h0, a1, st);

    // R8: scattered stream of writes then reads, with some bank reuse
    for (int i = 0; i < 64; i++)
      send((i * 37) % 128, (i * 53 + 1) % 128, 1'b1, i,
           {32'(i * 7919), 32'(~(i * 104729))}, a1, st);
    for (int i = 0; i < 64; i++)
      send((i * 37 + 64) % 128 == 0 ? (i * 37) % 128 : (i * 37) % 128,
           (i * 53 + 1) % 128, 1'b0, (i + 17) % 64, 64'h0, a1, st);

    repeat (20) @(negedge clk);
    check(sb_q.size() == 0, "R8 all responses seen", PKT_W'(sb_q.size()), 0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule